// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Controller

This block drives a parallel output port whose value changes only when a timer event occurs. Software loads the next pattern into a next-data register ahead of time. When the compare-match strobe chosen for a group arrives, that group copies its pending bits onto the port. The edge of the port therefore lines up with the timer event, not with the bus access that supplied the pattern.

The port is split into equal groups of adjacent bits. A control register holds one channel-select field for each group, so each group can follow its own timer channel. A per-bit enable mask sets which port bits the pattern logic drives at all. A standby input suspends all transfers and leaves every register unchanged.

All three registers and the current port value are reached through a small synchronous register port. Read data comes back one cycle after the address is presented.

Top module: `tpo_pattern_ctrl`

## Requirements
- R1: Group g drives port bits [4g+3:4g]. Group 3 covers bits 15:12, group 2 covers 11:8, group 1 covers 7:4 and group 0 covers 3:0.
- R2: The trigger register gives each group a 2-bit channel field at bits [2g+1:2g] (group 3 at 7:6, group 0 at 1:0). Field value k selects strobe input k, for k from 0 to 3.
- R3: A synchronous reset sets the next-data register, the enable mask and the port to zero, and sets the trigger register to 8'hFF.
- R4: In a cycle where a group's selected strobe is high, every enabled bit of that group loads its next-data bit into the port. The new value is visible on `pat_out` after that clock edge.
- R5: Port bits whose enable bit is 0 keep their previous value when their group is triggered.
- R6: If a next-data write and a trigger occur in the same cycle, the port takes the old next-data value. The written value stays pending for the next trigger.
- R7: All groups that select the same channel update on one strobe of that channel.
- R8: While `standby` is high, strobes cause no port change. The trigger register keeps its contents through standby, and only reset initializes it.
- R9: Register map: address 0 is next-data, address 1 is the enable mask, address 2 is the trigger register (bits 15:8 read 0), and address 3 reads the port. Writes to address 3 are ignored. `bus_rdata` returns the addressed value one cycle after the address is applied.
- R10: A strobe on a channel that no group selects leaves the port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cm_strobe | input | 4 | Compare-match pulses, one per timer channel |
| standby | input | 1 | Suspends transfers, keeps register contents |
| pat_out | output | 16 | Registered pattern output |

## Verification
The bench builds the block with its default parameters: four groups of four bits and four channels. This makes every select code reachable in every group. It also allows mixed select patterns, where two groups share a channel while another channel stays unused. Sixteen-bit patterns with mixed enable masks expose any swap of field positions or group boundaries, because each group ends up with a different value.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  typedef enum logic [1:0] {
    A_NEXT   = 2'd0,
    A_ENABLE = 2'd1,
    A_TRIG   = 2'd2,
    A_PORT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tpo_regs.sv
module tpo_regs #(
  parameter int PW     = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic [PW-1:0]     wdata,
  input  logic [PW-1:0]     port_q,
  output logic [PW-1:0]     rdata,
  output logic [PW-1:0]     nd_q,
  output logic [PW-1:0]     en_q,
  output logic [CTRL_W-1:0] sel_q
);
  import tpo_pkg::*;

  reg_addr_e a;
  assign a = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      nd_q  <= '0;
      en_q  <= '0;
      sel_q <= '1;
    end else if (wr) begin
      case (a)
        A_NEXT:   nd_q  <= wdata;
        A_ENABLE: en_q  <= wdata;
        A_TRIG:   sel_q <= wdata[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (a)
        A_NEXT:   rdata <= nd_q;
        A_ENABLE: rdata <= en_q;
        A_TRIG:   rdata <= {{(PW-CTRL_W){1'b0}}, sel_q};
        default:  rdata <= port_q;
      endcase
    end
  end

  // R3: the trigger register comes out of reset selecting the top channel
  p_trig_reset_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == {CTRL_W{1'b1}}));

  // R8: no trigger-register write means its contents stay, standby or not
  p_trig_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_TRIG) |=> $stable(sel_q));
endmodule

// File: rtl/tpo_trig_sel.sv
module tpo_trig_sel #(
  parameter int CH_N  = 4,
  parameter int SEL_W = 2
) (
  input  logic [CH_N-1:0]  strobe,
  input  logic [SEL_W-1:0] sel,
  input  logic             standby,
  output logic             fire
);
  always_comb fire = strobe[sel] & ~standby;
endmodule

// File: rtl/tpo_group_out.sv
module tpo_group_out #(
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [GRP_W-1:0] nd,
  input  logic [GRP_W-1:0] en,
  output logic [GRP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (fire) q <= (en & nd) | (~en & q);
  end

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    // R5: a masked bit never moves
    p_masked_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> $stable(q[i]));
    // R4: an enabled bit takes next-data on its trigger
    p_enabled_load_r4: assert property (@(posedge clk) disable iff (rst)
      (fire && en[i]) |=> (q[i] == $past(nd[i])));
  end
endmodule

// File: rtl/tpo_pattern_ctrl.sv
module tpo_pattern_ctrl #(
  parameter int GROUPS = 4,
  parameter int GRP_W  = 4,
  parameter int CH_N   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                bus_addr,
  input  logic                      bus_wr,
  input  logic [GROUPS*GRP_W-1:0]   bus_wdata,
  output logic [GROUPS*GRP_W-1:0]   bus_rdata,
  input  logic [CH_N-1:0]           cm_strobe,
  input  logic                      standby,
  output logic [GROUPS*GRP_W-1:0]   pat_out
);
  localparam int PW     = GROUPS * GRP_W;
  localparam int SEL_W  = $clog2(CH_N);
  localparam int CTRL_W = GROUPS * SEL_W;

  logic [PW-1:0]     nd_q, en_q, port_q;
  logic [CTRL_W-1:0] sel_q;
  logic [GROUPS-1:0] fire;

  tpo_regs #(.PW(PW), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .port_q(port_q), .rdata(bus_rdata), .nd_q(nd_q), .en_q(en_q), .sel_q(sel_q)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    tpo_trig_sel #(.CH_N(CH_N), .SEL_W(SEL_W)) u_sel (
      .strobe(cm_strobe), .sel(sel_q[g*SEL_W +: SEL_W]),
      .standby(standby), .fire(fire[g])
    );
    tpo_group_out #(.GRP_W(GRP_W)) u_out (
      .clk(clk), .rst(rst), .fire(fire[g]),
      .nd(nd_q[g*GRP_W +: GRP_W]), .en(en_q[g*GRP_W +: GRP_W]),
      .q(port_q[g*GRP_W +: GRP_W])
    );
  end

  assign pat_out = port_q;

  // R8: standby freezes the port
  p_standby_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    standby |=> $stable(pat_out));
  // R10: no strobe at all leaves the port alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cm_strobe == '0) |=> $stable(pat_out));
endmodule

// File: tb/tb_tpo_pattern_ctrl.sv
module tb_tpo_pattern_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [3:0]  cm_strobe = 0;
  logic        standby = 0;
  logic [15:0] pat_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model;

  always #5 clk = ~clk;

  tpo_pattern_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cm_strobe(cm_strobe),
    .standby(standby), .pat_out(pat_out)
  );

  // fields: nd[55:40] en[39:24] ctrl[23:16] strobe[3:0]
  localparam logic [55:0] VEC [8] = '{
    {16'hA5C3, 16'hFFFF, 8'hFF, 12'h0, 4'b1000},
    {16'h1234, 16'hFFFF, 8'hFF, 12'h0, 4'b0111},
    {16'h1234, 16'h00FF, 8'hFF, 12'h0, 4'b1000},
    {16'hFFFF, 16'hF0F0, 8'hE4, 12'h0, 4'b0001},
    {16'hFFFF, 16'hF0F0, 8'hE4, 12'h0, 4'b0010},
    {16'h0000, 16'hFFFF, 8'hE4, 12'h0, 4'b0100},
    {16'h0000, 16'hFFFF, 8'h00, 12'h0, 4'b0001},
    {16'h6789, 16'h0F0F, 8'h1B, 12'h0, 4'b1001}
  };

  function automatic logic [15:0] step(logic [15:0] cur, logic [15:0] nd,
                                       logic [15:0] en, logic [7:0] ctrl,
                                       logic [3:0] stb);
    logic [15:0] r = cur;
    for (int g = 0; g < 4; g++) begin
      if (stb[ctrl[2*g +: 2]])
        for (int b = 4*g; b < 4*g+4; b++) if (en[b]) r[b] = nd[b];
    end
    return r;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(logic [3:0] s);
    @(negedge clk); cm_strobe = s;
    @(negedge clk); cm_strobe = 0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R3 reset state
    check("R3 port", pat_out, 16'h0000);
    rd_reg(2'd0, d); check("R3 next-data", d, 16'h0000);
    rd_reg(2'd1, d); check("R3 enable", d, 16'h0000);
    rd_reg(2'd2, d); check("R3 trig", d, 16'h00FF);
    pulse(4'b1111); check("R3 enable-off no output", pat_out, 16'h0000);

    // table walk: R1 R2 R4 R5 R7 R10
    model = 16'h0000;
    for (int i = 0; i < 8; i++) begin
      wr_reg(2'd0, VEC[i][55:40]);
      wr_reg(2'd1, VEC[i][39:24]);
      wr_reg(2'd2, {8'h00, VEC[i][23:16]});
      pulse(VEC[i][3:0]);
      model = step(model, VEC[i][55:40], VEC[i][39:24], VEC[i][23:16], VEC[i][3:0]);
      check("R1 R2 R4 R5 R7 R10 table", pat_out, model);
    end
    // model now 0009

    // R9 readback
    rd_reg(2'd2, d); check("R9 trig readback", d, 16'h001B);
    rd_reg(2'd1, d); check("R9 enable readback", d, 16'h0F0F);
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd3, d); check("R9 port read, write ignored", d, 16'h0009);

    // R6 same-cycle write and trigger: ctrl 1B -> group0 on ch3
    wr_reg(2'd0, 16'h0003);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 16'h000C; bus_wr = 1; cm_strobe = 4'b1000;
    @(negedge clk); bus_wr = 0; cm_strobe = 0;
    check("R6 old value taken", pat_out, 16'h0003);
    pulse(4'b1000);
    check("R6 new value pending", pat_out, 16'h000C);

    // R8 standby: strobes ignored, trig kept
    wr_reg(2'd0, 16'hFFFF);
    wr_reg(2'd1, 16'hFFFF);
    @(negedge clk); standby = 1;
    pulse(4'b1111);
    check("R8 standby no transfer", pat_out, 16'h000C);
    rd_reg(2'd2, d); check("R8 trig kept in standby", d, 16'h001B);
    @(negedge clk); standby = 0;
    rd_reg(2'd2, d); check("R8 trig kept after standby", d, 16'h001B);
    pulse(4'b0001);
    check("R8 R1 transfer resumes group3", pat_out, 16'hF00C);

    // R10 unused channel: ctrl 1B uses ch0..3; pick ctrl all ch2
    wr_reg(2'd2, 16'h00AA);
    wr_reg(2'd0, 16'h0000);
    pulse(4'b1011);
    check("R10 unselected channels", pat_out, 16'hF00C);
    pulse(4'b0100);
    check("R7 all groups on ch2", pat_out, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule